// File: doc/BRIEF.md
# Periodic Conversion-Start Timer

This block is a 16-bit time-base timer whose only job is to pace an external data converter. A counter runs against a programmable period in one of three counting modes, or is held still. A compare value and a selectable event condition mark one point in each counter cycle. Each time that point is reached, an event is raised. The events pass through an enable gate and an event-count divider, and the result is a one-clock start-of-conversion pulse.

The counter does not run on the system clock directly. It advances on a tick from two division stages in series. The first stage is a fixed divider given by a parameter, which defaults to 2. The second is a power-of-two divider selected at run time. The conversion rate is set by the period and the counting mode. The compare value only places the pulse inside the counter cycle.

All configuration inputs are plain levels that the surrounding logic keeps stable while the block runs. They may be changed at any time. The block then goes on from its present counter state.

Top module: `pwm_soc_timer`

## Requirements
- R1: After a synchronous active-low reset, `tb_count` is 0, `tb_dir_up` is 1 and `soc_pulse` is 0.
- R2: With `cfg_mode` = 2'b00 (up), the counter steps 0,1,…,P and then wraps to 0. A trigger that fires once per counter cycle repeats every (P+1)·D system clocks. D = 2·2^`cfg_clk_div` with the default fixed divider of 2.
- R3: With `cfg_mode` = 2'b01 (down), `tb_dir_up` is 0 and the counter steps P,…,1,0 and then reloads P. A once-per-cycle trigger repeats every (P+1)·D clocks.
- R4: With `cfg_mode` = 2'b10 (up-down), the counter rises to P and then falls to 0. One counter cycle is 2·P ticks. `tb_dir_up` goes to 0 on the tick that leaves P and back to 1 on the tick that leaves 0.
- R5: With `cfg_mode` = 2'b11 (freeze), the count stays at its value and no pulse is produced. Choosing a running mode again resumes counting from the held value.
- R6: While `cfg_trig_en` is 0, no pulse is produced, and the event-count divider is cleared to zero.
- R7: `cfg_evt_count` = N (1..3) issues one pulse for every N qualifying events. N = 0 issues none.
- R8: A compare value above the period never matches, so no compare pulse is produced.
- R9: `soc_pulse` is high for exactly one clock. In the cycle it is high, the counter already shows the value after the event. For a compare-up event in up mode with C < P, that value is C+1.
- R10: `cfg_clk_div` = k divides the counter tick rate by a further 2^k, so the pulse interval grows by the same factor.
- R11: `cfg_trig_sel` selects the event as follows:
  - 1: the counter is at 0.
  - 2: the counter is at the period.
  - 3: the count equals compare while counting up.
  - 4: the count equals compare while counting down.
  - 0, 5, 6 and 7: no event.

  A compare-up selection produces nothing while counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Count mode: 00 up, 01 down, 10 up-down, 11 freeze |
| cfg_period | input | 16 | Period value P |
| cfg_compare | input | 16 | Compare value C |
| cfg_clk_div | input | 3 | Inner tick divider exponent k (divide by 2^k) |
| cfg_trig_sel | input | 3 | Event select (see R11) |
| cfg_trig_en | input | 1 | Trigger enable |
| cfg_evt_count | input | 2 | Events per pulse N; 0 disables pulses |
| soc_pulse | output | 1 | One-clock start-of-conversion pulse |
| tb_count | output | 16 | Current counter value |
| tb_dir_up | output | 1 | 1 while counting up, 0 while counting down |

## Verification
In up-down mode, a compare-up event with the compare value equal to the period lands on the same tick as the direction reversal. The event is qualified by the direction held before the tick, so it must still fire, while the counter and flag turn around at that same edge. The bench sets C = P = 6 and measures the pulse interval, which must be 24 clocks. In the pulse cycle it expects a count of 5 and a direction flag of 0. A wrong qualification either suppresses the pulse or shifts it by a full half-cycle.

// File: rtl/pwm_soc_pkg.sv
// Package: shared encodings for the conversion-start timer.
// Assumes: mode and select codes are fixed by the requirements.
package pwm_soc_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'b00,
        MODE_DOWN   = 2'b01,
        MODE_UPDOWN = 2'b10,
        MODE_FREEZE = 2'b11
    } tb_mode_e;

    localparam logic [2:0] SEL_ZERO   = 3'd1;
    localparam logic [2:0] SEL_PERIOD = 3'd2;
    localparam logic [2:0] SEL_CMP_UP = 3'd3;
    localparam logic [2:0] SEL_CMP_DN = 3'd4;
endpackage

// File: rtl/pwm_tick_divider.sv
// Module: produces a one-clock counter tick every OUTER_DIV * 2^div clocks.
// Assumes: OUTER_DIV >= 1; a smaller divider takes effect at once.
module pwm_tick_divider #(
    parameter int OUTER_DIV = 2,
    parameter int DIV_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_exp,
    output logic             tick
);
    localparam int PS_W = $clog2(OUTER_DIV + 1) + (1 << DIV_W) - 1;
    localparam logic [PS_W-1:0] OUTER_V = PS_W'(OUTER_DIV);
    localparam logic [PS_W-1:0] PS_ONE  = PS_W'(1);

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] limit;

    // Purpose: terminal count for the combined divide ratio.
    always_comb limit = (OUTER_V << div_exp) - PS_ONE;

    assign tick = (ps_cnt >= limit);

    // Purpose: free-running divide counter, restarted at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    ps_cnt <= '0;
        else if (tick) ps_cnt <= '0;
        else           ps_cnt <= ps_cnt + PS_ONE;
    end

    // R10: between two ticks at least OUTER_DIV-1 idle clocks pass (checked for ratio >= 2)
    assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && OUTER_DIV >= 2) |=> !tick);
endmodule

// File: rtl/pwm_time_base.sv
// Module: time-base counter with up, down, up-down and freeze modes.
// Assumes: moves only on tick; the direction flag reads 1 for up-count.
module pwm_time_base
    import pwm_soc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tb_mode_e         mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: advance the counter and direction once per tick by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            unique case (mode)
                MODE_UP: begin
                    dir_up <= 1'b1;
                    cnt    <= (cnt >= period) ? '0 : cnt + ONE;
                end
                MODE_DOWN: begin
                    dir_up <= 1'b0;
                    cnt    <= (cnt == '0 || cnt > period) ? period : cnt - ONE;
                end
                MODE_UPDOWN: begin
                    if (period == '0) begin
                        cnt    <= '0;
                        dir_up <= 1'b1;
                    end else if (dir_up) begin
                        if (cnt >= period) begin
                            cnt    <= period - ONE;
                            dir_up <= 1'b0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end else if (cnt == '0) begin
                        cnt    <= ONE;
                        dir_up <= 1'b1;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREEZE) |=> $stable(cnt));
    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UP && cnt < period) |=> (cnt == $past(cnt) + ONE));
    assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_DOWN && cnt == '0) |=> (cnt == $past(period)));
    assert_turn_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == MODE_UPDOWN && dir_up && cnt >= period && period != '0) |=> !dir_up);
endmodule

// File: rtl/pwm_soc_trigger.sv
// Module: selects the qualifying event, gates it and divides the event count.
// Assumes: inputs show the counter value held before this tick's update.
module pwm_soc_trigger
    import pwm_soc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EVT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             frozen,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] compare,
    input  logic [2:0]       sel,
    input  logic             enable,
    input  logic [EVT_W-1:0] evt_need,
    output logic             soc
);
    logic             hit;
    logic             evt;
    logic [EVT_W-1:0] evt_cnt;
    logic [EVT_W:0]   evt_next;

    // Purpose: decode the chosen event condition from counter state.
    always_comb begin
        unique case (sel)
            SEL_ZERO:   hit = (cnt == '0);
            SEL_PERIOD: hit = (cnt == period);
            SEL_CMP_UP: hit = (cnt == compare) && dir_up;
            SEL_CMP_DN: hit = (cnt == compare) && !dir_up;
            default:    hit = 1'b0;
        endcase
    end

    assign evt      = tick && !frozen && hit;
    assign evt_next = {1'b0, evt_cnt} + (EVT_W + 1)'(1);

    // Purpose: count qualifying events and emit one pulse per N events.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            evt_cnt <= '0;
            soc     <= 1'b0;
        end else if (evt && evt_need != '0) begin
            if (evt_next >= {1'b0, evt_need}) begin
                evt_cnt <= '0;
                soc     <= 1'b1;
            end else begin
                evt_cnt <= evt_next[EVT_W-1:0];
                soc     <= 1'b0;
            end
        end else begin
            soc <= 1'b0;
        end
    end

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !soc);
    assert_zero_count_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_need == '0) |=> !soc);
    assert_frozen_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> !soc);
endmodule

// File: rtl/pwm_soc_timer.sv
// Module: top of the conversion-start timer; ties divider, counter and trigger.
// Assumes: configuration inputs are levels owned by the surrounding logic.
module pwm_soc_timer
    import pwm_soc_pkg::*;
#(
    parameter int OUTER_DIV = 2,
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 3,
    parameter int EVT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_compare,
    input  logic [DIV_W-1:0] cfg_clk_div,
    input  logic [2:0]       cfg_trig_sel,
    input  logic             cfg_trig_en,
    input  logic [EVT_W-1:0] cfg_evt_count,
    output logic             soc_pulse,
    output logic [CNT_W-1:0] tb_count,
    output logic             tb_dir_up
);
    tb_mode_e mode;
    logic     tick;

    assign mode = tb_mode_e'(cfg_mode);

    pwm_tick_divider #(.OUTER_DIV(OUTER_DIV), .DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_exp(cfg_clk_div), .tick(tick)
    );

    pwm_time_base #(.CNT_W(CNT_W)) u_base (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
        .period(cfg_period), .cnt(tb_count), .dir_up(tb_dir_up)
    );

    pwm_soc_trigger #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .frozen(mode == MODE_FREEZE), .cnt(tb_count), .dir_up(tb_dir_up),
        .period(cfg_period), .compare(cfg_compare), .sel(cfg_trig_sel),
        .enable(cfg_trig_en), .evt_need(cfg_evt_count), .soc(soc_pulse)
    );

    // R9: start pulse lasts a single clock (default divider of 2 spaces ticks)
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_pulse && OUTER_DIV >= 2) |=> !soc_pulse);
    // R1: state straight after reset release
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (tb_count == '0 && tb_dir_up && !soc_pulse));
endmodule

// File: tb/test_pwm_soc_timer.sv
module test_pwm_soc_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b11;
    logic [15:0] cfg_period = 16'd9;
    logic [15:0] cfg_compare = 16'd4;
    logic [2:0]  cfg_clk_div = 3'd0;
    logic [2:0]  cfg_trig_sel = 3'd3;
    logic        cfg_trig_en = 1'b0;
    logic [1:0]  cfg_evt_count = 2'd1;
    logic        soc_pulse;
    logic [15:0] tb_count;
    logic        tb_dir_up;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int wd = 0;

    always #5 clk = ~clk;

    pwm_soc_timer i_pwm_soc_timer (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_period(cfg_period),
        .cfg_compare(cfg_compare), .cfg_clk_div(cfg_clk_div),
        .cfg_trig_sel(cfg_trig_sel), .cfg_trig_en(cfg_trig_en),
        .cfg_evt_count(cfg_evt_count), .soc_pulse(soc_pulse),
        .tb_count(tb_count), .tb_dir_up(tb_dir_up)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            failures++;
            $display("FAIL watchdog (all requirements): actual cycles=%0d expected<100000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input int p, input int c, input int k,
                       input int s, input bit en, input int n);
        cfg_mode = m; cfg_period = 16'(p); cfg_compare = 16'(c);
        cfg_clk_div = 3'(k); cfg_trig_sel = 3'(s); cfg_trig_en = en;
        cfg_evt_count = 2'(n);
    endtask

    task automatic wait_pulse(input int maxc, output bit got);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            step();
            if (soc_pulse) begin
                got = 1'b1;
                return;
            end
        end
    endtask

    task automatic interval(input int maxc, output int gap);
        bit got;
        int t1;
        gap = -1;
        wait_pulse(maxc, got);
        if (!got) return;
        t1 = cyc;
        wait_pulse(maxc, got);
        if (got) gap = cyc - t1;
    endtask

    task automatic count_pulses(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (soc_pulse) pulses++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        chk(tb_count == 0, "R1 count", int'(tb_count), 0);
        chk(tb_dir_up == 1'b1, "R1 dir", int'(tb_dir_up), 1);
        chk(soc_pulse == 1'b0, "R1 soc", int'(soc_pulse), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_up();
        int gap;
        bit got;
        int mx = 0;
        cfg(2'b00, 9, 4, 0, 3, 1'b1, 1);
        interval(200, gap);
        chk(gap == 20, "R2 up interval", gap, 20);
        wait_pulse(200, got);
        chk(got && tb_count == 5, "R9 count at pulse", int'(tb_count), 5);
        chk(tb_dir_up == 1'b1, "R9 dir at pulse", int'(tb_dir_up), 1);
        step();
        chk(soc_pulse == 1'b0, "R9 single clock", int'(soc_pulse), 0);
        for (int i = 0; i < 40; i++) begin
            step();
            if (int'(tb_count) > mx) mx = int'(tb_count);
        end
        chk(mx == 9, "R2 max count", mx, 9);
    endtask

    task automatic t_div();
        int gap;
        cfg(2'b00, 9, 4, 2, 3, 1'b1, 1);
        interval(400, gap);
        chk(gap == 80, "R10 divided interval", gap, 80);
    endtask

    task automatic t_evt_count();
        int gap;
        int n;
        cfg(2'b00, 9, 4, 0, 3, 1'b1, 3);
        interval(400, gap);
        chk(gap == 60, "R7 three events per pulse", gap, 60);
        cfg(2'b00, 9, 4, 0, 3, 1'b1, 0);
        count_pulses(200, n);
        chk(n == 0, "R7 zero count silent", n, 0);
    endtask

    task automatic t_cmp_over();
        int n;
        cfg(2'b00, 9, 12, 0, 3, 1'b1, 1);
        count_pulses(200, n);
        chk(n == 0, "R8 compare above period", n, 0);
    endtask

    task automatic t_down();
        int gap;
        int n;
        bit got;
        int mx = 0;
        int mn = 99;
        cfg(2'b01, 9, 4, 0, 4, 1'b1, 1);
        interval(200, gap);
        chk(gap == 20, "R3 down interval", gap, 20);
        wait_pulse(200, got);
        chk(got && tb_count == 3, "R3 count at pulse", int'(tb_count), 3);
        chk(tb_dir_up == 1'b0, "R3 dir down", int'(tb_dir_up), 0);
        for (int i = 0; i < 40; i++) begin
            step();
            if (int'(tb_count) > mx) mx = int'(tb_count);
            if (int'(tb_count) < mn) mn = int'(tb_count);
        end
        chk(mx == 9 && mn == 0, "R3 reload range", mx * 100 + mn, 900);
        cfg(2'b01, 9, 4, 0, 3, 1'b1, 1);
        count_pulses(100, n);
        chk(n == 0, "R11 compare-up silent while down", n, 0);
    endtask

    task automatic t_updown();
        int gap;
        bit got;
        int mx = 0;
        cfg(2'b10, 6, 3, 0, 3, 1'b1, 1);
        interval(200, gap);
        chk(gap == 24, "R4 up-down interval", gap, 24);
        wait_pulse(200, got);
        chk(got && tb_count == 4 && tb_dir_up, "R4 mid compare", int'(tb_count), 4);
        for (int i = 0; i < 30; i++) begin
            step();
            if (int'(tb_count) > mx) mx = int'(tb_count);
        end
        chk(mx == 6, "R4 peak", mx, 6);
        // compare at period: event and reversal on the same tick
        cfg(2'b10, 6, 6, 0, 3, 1'b1, 1);
        interval(200, gap);
        chk(gap == 24, "R4 coincident interval", gap, 24);
        chk(tb_count == 5 && !tb_dir_up, "R4 coincident state",
            int'(tb_count) * 10 + int'(tb_dir_up), 50);
    endtask

    task automatic t_freeze();
        int h;
        int n = 0;
        bit moved = 1'b0;
        cfg(2'b00, 9, 4, 0, 3, 1'b1, 1);
        step(); step(); step();
        cfg_mode = 2'b11;
        step();
        h = int'(tb_count);
        for (int i = 0; i < 30; i++) begin
            step();
            if (int'(tb_count) != h) moved = 1'b1;
            if (soc_pulse) n++;
        end
        chk(!moved, "R5 held count", int'(tb_count), h);
        chk(n == 0, "R5 no pulse frozen", n, 0);
        cfg_mode = 2'b00;
        for (int i = 0; i < 10; i++) begin
            step();
            if (int'(tb_count) != h) break;
        end
        chk(int'(tb_count) == ((h == 9) ? 0 : h + 1), "R5 resume from held",
            int'(tb_count), (h == 9) ? 0 : h + 1);
    endtask

    task automatic t_enable();
        int n;
        bit got;
        int t0;
        cfg(2'b00, 9, 4, 0, 3, 1'b0, 1);
        count_pulses(100, n);
        chk(n == 0, "R6 disabled silent", n, 0);
        cfg(2'b00, 9, 4, 0, 3, 1'b1, 3);
        wait_pulse(400, got);
        wait_pulse(400, got);
        t0 = cyc;
        for (int i = 0; i < 25; i++) step();
        cfg_trig_en = 1'b0;
        for (int i = 0; i < 5; i++) step();
        cfg_trig_en = 1'b1;
        wait_pulse(400, got);
        chk(got && (cyc - t0) == 80, "R6 divider cleared", cyc - t0, 80);
    endtask

    task automatic t_select();
        bit got;
        int n;
        cfg(2'b00, 9, 4, 0, 1, 1'b1, 1);
        wait_pulse(200, got);
        wait_pulse(200, got);
        chk(got && tb_count == 1, "R11 zero event", int'(tb_count), 1);
        cfg(2'b00, 9, 4, 0, 2, 1'b1, 1);
        wait_pulse(200, got);
        wait_pulse(200, got);
        chk(got && tb_count == 0, "R11 period event", int'(tb_count), 0);
        cfg(2'b00, 9, 4, 0, 0, 1'b1, 1);
        count_pulses(100, n);
        chk(n == 0, "R11 no-event select", n, 0);
    endtask

    initial begin
        t_reset();
        t_up();
        t_div();
        t_evt_count();
        t_cmp_over();
        t_down();
        t_updown();
        t_freeze();
        t_enable();
        t_select();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule